// File: doc/BRIEF.md
# Execute-Only Flash Window Filter

This block sits between the bus and a flash array and decides, for every access, whether it may reach the array. One address window can be marked execute-only. While the guard is armed, an instruction fetch that lands in the window goes through to the flash as usual. A data read that lands in the window is stopped before it reaches the array and is answered with an error and all-zero data. The bus master that issued the access plays no part in this decision, so processor, DMA and debug reads are all treated alike.

Software programs the window through a small register port. There is a lower-bound register, an upper-bound register, an arming register that only accepts a write carrying an 8-bit key, and a read-only status word. The bounds are kept at 64-byte line granularity. The allow/block decision is combinational on the request. The response, with its error flag, appears one cycle later from a single register stage.

Top module: `xo_flash_filter`

## Requirements
- R1: After reset the guard is disarmed, both bounds read as zero, the status reads zero and no response is valid.
- R2: Register word index 0 holds the lower bound and index 1 holds the upper bound. Address bits [5:0] of a bound write are discarded, and those bits read back as zero.
- R3: A write to index 2 whose bits [31:24] equal 0x76 loads bit 0 into the arm flag, so 1 arms the guard and 0 disarms it. Reading index 2 returns the arm flag in bit 0.
- R4: A write to index 2 whose bits [31:24] differ from 0x76 leaves the arm flag unchanged.
- R5: Index 3 is a read-only status word with bit 0 set exactly while the guard is armed. Writes to index 3 change nothing.
- R6: While armed, a data read (req_fetch=0) whose 64-byte line lies in the window does not assert flash_en. One cycle later it is answered with rsp_valid=1, rsp_err=1 and rsp_data=0.
- R7: An instruction fetch (req_fetch=1) is never blocked. It asserts flash_en and is answered with the flash data and rsp_err=0, including when it falls inside an armed window.
- R8: The value on req_master never changes the decision or the response.
- R9: The window is inclusive of both bounds: a line hits when lower <= (addr>>6) <= upper. If the lower bound exceeds the upper bound, nothing hits.
- R10: While disarmed, every access passes. Accesses outside the window always pass.
- R11: A request in one cycle produces rsp_valid in exactly the next cycle, and rsp_err is high only together with rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Access request valid |
| req_addr | input | ADDR_W (20) | Access byte address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| req_master | input | MID_W (2) | Issuing master ID (no effect on the decision) |
| flash_en | output | 1 | Access forwarded to the flash |
| flash_addr | output | ADDR_W (20) | Address forwarded to the flash |
| flash_rdata | input | DATA_W (32) | Same-cycle flash read data |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | DATA_W (32) | Response data |
| rsp_err | output | 1 | Access error response |

## Verification
A wrong arm flag or a corrupted bound shows up in two places. It is visible on the very next register read of index 2 or 3. It also shows on the first data read near a bound: flash_en goes the wrong way in the same cycle, and rsp_err goes the wrong way one cycle later. Because of this, the random stimulus puts many addresses on the first and last line of the window and on the lines just beyond them, and it mixes in keyed and wrongly keyed writes. The bench also compares responses that differ only in master ID or only in access type. This exposes any dependence of the decision on the master or any blocking of fetches.

// File: rtl/xo_pkg.sv
package xo_pkg;
  localparam int REG_W   = 32;
  localparam int GRAN_LG = 6;
  localparam logic [7:0] ARM_KEY = 8'h76;

  typedef enum logic [1:0] {
    IDX_LO     = 2'd0,
    IDX_HI     = 2'd1,
    IDX_ARM    = 2'd2,
    IDX_STATUS = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/xo_cfg_regs.sv
module xo_cfg_regs
  import xo_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int LINE_W = ADDR_W - GRAN_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [LINE_W-1:0] lo_line,
  output logic [LINE_W-1:0] hi_line,
  output logic              armed
);
  logic [LINE_W-1:0] lo_d, hi_d;
  logic              armed_d;
  logic              lo_ce, hi_ce, arm_ce;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[GRAN_LG-1:0], wdata[23:1]};

  always_comb begin
    lo_ce   = we && (idx == IDX_LO);
    hi_ce   = we && (idx == IDX_HI);
    arm_ce  = we && (idx == IDX_ARM) && (wdata[31:24] == ARM_KEY);
    lo_d    = wdata[ADDR_W-1:GRAN_LG];
    hi_d    = wdata[ADDR_W-1:GRAN_LG];
    armed_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_line <= '0;
      hi_line <= '0;
      armed   <= 1'b0;
    end else begin
      if (lo_ce)  lo_line <= lo_d;
      if (hi_ce)  hi_line <= hi_d;
      if (arm_ce) armed   <= armed_d;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_LO:  rdata = REG_W'({lo_line, {GRAN_LG{1'b0}}});
      IDX_HI:  rdata = REG_W'({hi_line, {GRAN_LG{1'b0}}});
      IDX_ARM: rdata = REG_W'(armed);
      default: rdata = REG_W'(armed);
    endcase
  end
endmodule

// File: rtl/xo_window_match.sv
module xo_window_match
  import xo_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int LINE_W = ADDR_W - GRAN_LG
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINE_W-1:0] lo_line,
  input  logic [LINE_W-1:0] hi_line,
  output logic              hit
);
  logic [LINE_W-1:0] line;
  logic              unused_offs;

  assign unused_offs = ^addr[GRAN_LG-1:0];
  assign line        = addr[ADDR_W-1:GRAN_LG];

  always_comb begin
    hit = (line >= lo_line) && (line <= hi_line);
  end
endmodule

// File: rtl/xo_rsp_stage.sv
module xo_rsp_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              blocked,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  logic              valid_d, err_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = req_valid;
    err_d   = req_valid && blocked;
    data_d  = blocked ? '0 : flash_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      if (req_valid) rsp_data <= data_d;
    end
  end
endmodule

// File: rtl/xo_flash_filter.sv
module xo_flash_filter
  import xo_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int MID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_fetch,
  input  logic [MID_W-1:0]  req_master,
  output logic              flash_en,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  localparam int LINE_W = ADDR_W - GRAN_LG;

  logic [LINE_W-1:0] lo_line, hi_line;
  logic              prot_on;
  logic              win_hit;
  logic              blocked;
  logic              unused_master;

  assign unused_master = ^req_master;

  xo_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .idx     (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .lo_line (lo_line),
    .hi_line (hi_line),
    .armed   (prot_on)
  );

  xo_window_match #(.ADDR_W(ADDR_W)) u_match (
    .addr    (req_addr),
    .lo_line (lo_line),
    .hi_line (hi_line),
    .hit     (win_hit)
  );

  always_comb begin
    blocked    = req_valid && !req_fetch && prot_on && win_hit;
    flash_en   = req_valid && !blocked;
    flash_addr = req_addr;
  end

  xo_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .blocked     (blocked),
    .flash_rdata (flash_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_data)
  );
endmodule

// File: rtl/xo_flash_filter_chk.sv
module xo_flash_filter_chk #(
  parameter int ADDR_W = 20,
  parameter int LINE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              req_valid,
  input logic              req_fetch,
  input logic              flash_en,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              prot_on,
  input logic [LINE_W-1:0] lo_line,
  input logic [LINE_W-1:0] hi_line
);
  a_r11_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r11_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r7_fetch_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch) |-> flash_en);
  a_r7_fetch_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch) |=> !rsp_err);
  a_r6_stop_means_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flash_en) |=> rsp_err);
  a_r10_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_on) |-> flash_en);
  a_r9_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (lo_line > hi_line)) |-> flash_en);
  a_r4_bad_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && reg_wdata[31:24] != 8'h76) |=> $stable(prot_on));
  a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3) |=> $stable(prot_on));
endmodule

bind xo_flash_filter xo_flash_filter_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .req_valid (req_valid),
  .req_fetch (req_fetch),
  .flash_en  (flash_en),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .prot_on   (prot_on),
  .lo_line   (lo_line),
  .hi_line   (hi_line)
);

// File: tb/xo_flash_filter_bench.sv
`timescale 1ns/1ps
module xo_flash_filter_bench;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int MID_W  = 2;
  localparam int LINE_W = ADDR_W - 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_fetch = 1'b0;
  logic [MID_W-1:0]  req_master = '0;
  logic              flash_en;
  logic [ADDR_W-1:0] flash_addr;
  logic [DATA_W-1:0] flash_rdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [LINE_W-1:0] m_lo = '0, m_hi = '0;
  bit                m_on = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [DATA_W-1:0] fdata(input logic [ADDR_W-1:0] a);
    return {12'hC3A, a};
  endfunction

  assign flash_rdata = flash_en ? fdata(flash_addr) : 32'hDEAD_BEEF;

  xo_flash_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)) u_xo_flash_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_fetch(req_fetch), .req_master(req_master),
    .flash_en(flash_en), .flash_addr(flash_addr), .flash_rdata(flash_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_block(input logic [ADDR_W-1:0] a, input bit fetch);
    logic [LINE_W-1:0] ln;
    ln = a[ADDR_W-1:6];
    return m_on && !fetch && (ln >= m_lo) && (ln <= m_hi);
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (idx)
      2'd0: m_lo = d[ADDR_W-1:6];
      2'd1: m_hi = d[ADDR_W-1:6];
      2'd2: if (d[31:24] == 8'h76) m_on = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] idx, input string tag);
    logic [31:0] e;
    case (idx)
      2'd0: e = 32'({m_lo, 6'b0});
      2'd1: e = 32'({m_hi, 6'b0});
      default: e = 32'(m_on);
    endcase
    reg_addr = idx;
    #0.5;
    chk(reg_rdata == e, tag, 64'(reg_rdata), 64'(e));
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input bit fetch,
                        input logic [MID_W-1:0] mid, input string tag);
    bit blk;
    blk = exp_block(a, fetch);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_fetch = fetch; req_master = mid;
    #0.5;
    chk(flash_en == !blk, {tag, " flash_en"}, 64'(flash_en), 64'(!blk));
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R11 valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_err == blk, {tag, " err"}, 64'(rsp_err), 64'(blk));
    chk(rsp_data == (blk ? '0 : fdata(a)), {tag, " data"}, 64'(rsp_data),
        64'(blk ? '0 : fdata(a)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [ADDR_W-1:0] a;
    void'($urandom(32'h1F2E_3D4C));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, "R1 lo");
    rd(2'd1, "R1 hi");
    rd(2'd3, "R1 status");
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);

    // R2 bounds with low bits discarded
    wr(2'd0, 32'h0000_103F);
    wr(2'd1, 32'h0000_20FF);
    rd(2'd0, "R2 lo readback");
    rd(2'd1, "R2 hi readback");

    // R10 disarmed: in-window data read passes
    access(20'h01500, 1'b0, 2'd0, "R10 disarmed");

    // R4 wrong key
    wr(2'd2, 32'h7500_0001);
    rd(2'd3, "R4 wrong key status");
    access(20'h01500, 1'b0, 2'd1, "R4 still open");

    // R3 arm with key
    wr(2'd2, 32'h7600_0001);
    rd(2'd2, "R3 arm readback");
    rd(2'd3, "R5 status armed");

    // R6 / R9 bounds inclusive
    access(20'h01000, 1'b0, 2'd0, "R6 R9 first line");
    access(20'h020FF, 1'b0, 2'd0, "R6 R9 last line");
    access(20'h00FFF, 1'b0, 2'd0, "R9 below window");
    access(20'h02100, 1'b0, 2'd0, "R10 above window");
    // R7 fetch inside window
    access(20'h01840, 1'b1, 2'd0, "R7 fetch inside");
    // R8 master IDs alike
    for (int m = 0; m < 4; m++) access(20'h01844, 1'b0, MID_W'(m), "R8 master");

    // R5 write to status ignored
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, "R5 status write ignored");
    access(20'h01000, 1'b0, 2'd2, "R5 still blocking");

    // R4 wrong key cannot disarm
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, "R4 disarm refused");

    // R9 empty window
    wr(2'd0, 32'h0000_3000);
    access(20'h02000, 1'b0, 2'd0, "R9 empty window");
    access(20'h03000, 1'b0, 2'd0, "R9 empty at lo");

    // R3 disarm with key
    wr(2'd0, 32'h0000_1000);
    wr(2'd2, 32'h7600_0000);
    rd(2'd3, "R3 disarmed status");
    access(20'h01000, 1'b0, 2'd3, "R3 R10 disarmed pass");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) wr(2'd0, $urandom());
      else if (sel == 1) wr(2'd1, $urandom());
      else if (sel == 2) wr(2'd2, ($urandom_range(0, 1) != 0) ?
                                  {8'h76, 23'd0, 1'($urandom_range(0, 1))} : $urandom());
      else if (sel == 3) rd(2'($urandom_range(0, 3)), "R2 R3 R5 random read");
      else begin
        case ($urandom_range(0, 4))
          0: a = {m_lo, 6'($urandom())};
          1: a = {m_hi, 6'($urandom())};
          2: a = {m_lo - 1'b1, 6'($urandom())};
          3: a = {m_hi + 1'b1, 6'($urandom())};
          default: a = ADDR_W'($urandom());
        endcase
        access(a, 1'($urandom_range(0, 1)), MID_W'($urandom()), "R6 R7 R8 R9 R10 random");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule